// File: doc/BRIEF.md
# Split-Beat Misaligned Word Reader

This block connects a processor load port to a 32-bit memory made of four byte-wide banks. All four banks are driven by a single offset (word address) bus. A load request carries a byte address. The block returns the 32-bit little-endian word that starts at that byte.

A load whose address is a multiple of four costs one memory beat, and the bank lanes pass straight through. For any other address the word spans two bank rows, and one shared offset cannot reach both rows in the same beat. The block therefore reads offset N first and keeps the upper lanes of that beat. It then reads offset N+1 and takes the lower lanes. The two sets of lanes are merged and rotated right by the byte misalignment, so that each byte lands in its result position.

The request side is a valid/ready handshake. The response side is a single-cycle valid pulse with the word. The memory side is a read strobe, an offset bus and per-lane read data that arrive one cycle after the strobe.

Top module: `unaligned_load_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it, reqReady is 1, rspValid is 0 and memRead is 0.
- R2: A byte address A is split into offset N = A >> 2 (the upper OFFSET_W bits) and lane k = A mod 4 (the low two bits). Bank j drives memRdata bits 8j+7..8j, and byte address 4N+j lives in bank j at offset N.
- R3: For an aligned request (k = 0), memRead is high with memOffset = N in the acceptance cycle. No read is issued in the next cycle. rspValid rises two cycles after acceptance, with rspData equal to the bank data read at offset N.
- R4: For a misaligned request (k ≠ 0), memRead is high with memOffset = N in the acceptance cycle. memRead is high again with memOffset = N+1 in the following cycle.
- R5: Byte i of rspData (bits 8i+7..8i) equals the memory byte at address A+i. For a misaligned request, the top k byte positions come from the second beat.
- R6: The second-beat offset N+1 wraps to 0 when N is the last offset (2^OFFSET_W − 1). The result then reads bytes from address 0 upward.
- R7: reqReady is 0 in every cycle after acceptance until the response cycle, and it is 1 in the response cycle. A reqValid asserted while reqReady is 0 is ignored and does not change the response.
- R8: rspValid is high for exactly one cycle per accepted request.
- R9: memRead is 0 while the block is idle and reqValid is 0.
- R10: For a misaligned request, rspValid rises three cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Load request present |
| reqReady | output | 1 | Block can accept a request |
| reqAddr | input | OFFSET_W+2 | Byte address of the load |
| rspValid | output | 1 | One-cycle pulse: rspData holds the result |
| rspData | output | 32 | Little-endian loaded word |
| memRead | output | 1 | Read strobe to all banks |
| memOffset | output | OFFSET_W | Shared bank row offset |
| memRdata | input | 32 | Bank lanes, valid one cycle after memRead |

## Verification
Two cases are the hardest to reach from the ports. The first is a misaligned load at the last row, where the second beat must wrap to offset 0. The second is a request held on reqValid while a two-beat load is still in flight. The bench sweeps every byte address of a 16-row memory under two different content patterns, and this sweep includes all three misaligned addresses in the last row. In one pass the bench also keeps reqValid high with a different address during the busy cycles, then confirms that the response still belongs to the first address.

// File: rtl/ulu_pkg.sv
package ulu_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } uluState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic captureReq;   // latch offset and lane of the accepted request
    logic issueRead;    // a bank read goes out this cycle
    logic selNext;      // drive the saved offset plus one
    logic holdFirst;    // keep the first-beat lanes
    logic loadAligned;  // response from a single beat
    logic loadMerged;   // response from held lanes plus current lanes
  } uluStrobe_t;

endpackage

// File: rtl/ulu_ctrl.sv
module ulu_ctrl
  import ulu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       savedAligned,
  output logic       reqReady,
  output logic       rspValid,
  output logic       memRead,
  output uluStrobe_t strobe
);

  uluState_e state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    reqReady  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.captureReq = 1'b1;
          strobe.issueRead  = 1'b1;
          stateNext         = ST_FIRST;
        end
      end
      ST_FIRST: begin
        if (savedAligned) begin
          strobe.loadAligned = 1'b1;
          stateNext          = ST_IDLE;
        end else begin
          strobe.issueRead = 1'b1;
          strobe.selNext   = 1'b1;
          strobe.holdFirst = 1'b1;
          stateNext        = ST_SECOND;
        end
      end
      ST_SECOND: begin
        strobe.loadMerged = 1'b1;
        stateNext         = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      rspValid <= 1'b0;
    end else begin
      state    <= stateNext;
      rspValid <= strobe.loadAligned | strobe.loadMerged;
    end
  end

  assign memRead = strobe.issueRead;

endmodule

// File: rtl/ulu_lane_rotator.sv
module ulu_lane_rotator #(
  parameter int LANE_COUNT = 4,
  parameter int LANE_W     = 8,
  localparam int SEL_W     = $clog2(LANE_COUNT),
  localparam int WORD_W    = LANE_COUNT * LANE_W
) (
  input  logic [WORD_W-1:0] wordIn,
  input  logic [SEL_W-1:0]  amount,
  output logic [WORD_W-1:0] wordOut
);

  // result lane i takes input lane (i + amount) mod LANE_COUNT
  for (genvar i = 0; i < LANE_COUNT; i++) begin : g_lane
    logic [SEL_W-1:0] srcIdx;
    assign srcIdx = SEL_W'(i) + amount;
    always_comb begin
      wordOut[i*LANE_W +: LANE_W] = '0;
      for (int s = 0; s < LANE_COUNT; s++) begin
        if (srcIdx == SEL_W'(s)) wordOut[i*LANE_W +: LANE_W] = wordIn[s*LANE_W +: LANE_W];
      end
    end
  end

endmodule

// File: rtl/ulu_datapath.sv
module ulu_datapath
  import ulu_pkg::*;
#(
  parameter int OFFSET_W   = 4,
  parameter int LANE_COUNT = 4,
  parameter int LANE_W     = 8,
  localparam int SEL_W     = $clog2(LANE_COUNT),
  localparam int ADDR_W    = OFFSET_W + SEL_W,
  localparam int WORD_W    = LANE_COUNT * LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  uluStrobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [WORD_W-1:0] memRdata,
  output logic [OFFSET_W-1:0] memOffset,
  output logic              savedAligned,
  output logic [WORD_W-1:0] rspData
);

  logic [OFFSET_W-1:0] savedOffset;
  logic [SEL_W-1:0]    savedLane;
  logic [WORD_W-1:0]   holdWord;
  logic [WORD_W-1:0]   mergedWord;
  logic [WORD_W-1:0]   rotatedWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      savedOffset <= '0;
      savedLane   <= '0;
      holdWord    <= '0;
      rspData     <= '0;
    end else begin
      if (strobe.captureReq) begin
        savedOffset <= reqAddr[ADDR_W-1:SEL_W];
        savedLane   <= reqAddr[SEL_W-1:0];
      end
      if (strobe.holdFirst) holdWord <= memRdata;
      if (strobe.loadAligned || strobe.loadMerged) rspData <= rotatedWord;
    end
  end

  // offset N on the first beat, N+1 (wrapping) on the second
  assign memOffset    = strobe.selNext ? savedOffset + OFFSET_W'(1) : reqAddr[ADDR_W-1:SEL_W];
  assign savedAligned = (savedLane == '0);

  // lanes at or above the misalignment come from the held first beat
  for (genvar j = 0; j < LANE_COUNT; j++) begin : g_merge
    logic fromHold;
    assign fromHold = strobe.loadMerged && (SEL_W'(j) >= savedLane);
    assign mergedWord[j*LANE_W +: LANE_W] =
      fromHold ? holdWord[j*LANE_W +: LANE_W] : memRdata[j*LANE_W +: LANE_W];
  end

  ulu_lane_rotator #(
    .LANE_COUNT(LANE_COUNT),
    .LANE_W    (LANE_W)
  ) u_rot (
    .wordIn (mergedWord),
    .amount (savedLane),
    .wordOut(rotatedWord)
  );

endmodule

// File: rtl/unaligned_load_unit.sv
module unaligned_load_unit
  import ulu_pkg::*;
#(
  parameter int OFFSET_W = 4,
  localparam int LANE_COUNT = 4,
  localparam int LANE_W     = 8,
  localparam int SEL_W      = $clog2(LANE_COUNT),
  localparam int ADDR_W     = OFFSET_W + SEL_W,
  localparam int WORD_W     = LANE_COUNT * LANE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [ADDR_W-1:0]   reqAddr,
  output logic                rspValid,
  output logic [WORD_W-1:0]   rspData,
  output logic                memRead,
  output logic [OFFSET_W-1:0] memOffset,
  input  logic [WORD_W-1:0]   memRdata
);

  uluStrobe_t strobe;
  logic       savedAligned;

  ulu_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .savedAligned(savedAligned),
    .reqReady    (reqReady),
    .rspValid    (rspValid),
    .memRead     (memRead),
    .strobe      (strobe)
  );

  ulu_datapath #(
    .OFFSET_W  (OFFSET_W),
    .LANE_COUNT(LANE_COUNT),
    .LANE_W    (LANE_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqAddr     (reqAddr),
    .memRdata    (memRdata),
    .memOffset   (memOffset),
    .savedAligned(savedAligned),
    .rspData     (rspData)
  );

endmodule

// File: rtl/ulu_checker.sv
module ulu_checker #(
  parameter int OFFSET_W = 4,
  localparam int ADDR_W  = OFFSET_W + 2
) (
  input logic                clk,
  input logic                rstN,
  input logic                reqValid,
  input logic                reqReady,
  input logic [ADDR_W-1:0]   reqAddr,
  input logic                rspValid,
  input logic                memRead,
  input logic [OFFSET_W-1:0] memOffset
);

  logic accepted;
  assign accepted = reqValid && reqReady;

  // R3
  aligned_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && reqAddr[1:0] == 2'b00) |-> ##2 rspValid);

  // R3
  aligned_single_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && reqAddr[1:0] == 2'b00) |=> !memRead);

  // R4
  first_beat_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    accepted |-> (memRead && memOffset == reqAddr[ADDR_W-1:2]));

  // R6
  second_beat_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && reqAddr[1:0] != 2'b00) |=>
      (memRead && memOffset == OFFSET_W'($past(reqAddr[ADDR_W-1:2]) + 1'b1)));

  // R10
  misaligned_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && reqAddr[1:0] != 2'b00) |-> ##3 rspValid);

  // R7
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    accepted |=> !reqReady);

  // R7
  ready_on_response_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> reqReady);

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && !reqValid) |-> !memRead);

endmodule

bind unaligned_load_unit ulu_checker #(.OFFSET_W(OFFSET_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .reqAddr  (reqAddr),
  .rspValid (rspValid),
  .memRead  (memRead),
  .memOffset(memOffset)
);

// File: tb/unaligned_load_unit_bench.sv
`timescale 1ns/1ps
module unaligned_load_unit_bench;

  localparam int OFFSET_W = 4;
  localparam int ADDR_W   = OFFSET_W + 2;
  localparam int BYTES    = 1 << ADDR_W;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                reqValid = 1'b0;
  logic                reqReady;
  logic [ADDR_W-1:0]   reqAddr = '0;
  logic                rspValid;
  logic [31:0]         rspData;
  logic                memRead;
  logic [OFFSET_W-1:0] memOffset;
  logic [31:0]         memRdata = '0;

  int seed = 0;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  unaligned_load_unit #(.OFFSET_W(OFFSET_W)) u_unaligned_load_unit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .rspValid(rspValid), .rspData(rspData),
    .memRead(memRead), .memOffset(memOffset), .memRdata(memRdata)
  );

  function automatic logic [7:0] memByte(int addr, int s);
    return 8'(((addr * 29) + (s * 7) + (addr >> 3)) ^ (s * 53 + 1));
  endfunction

  // bank model: one-cycle read latency, lane j of row n is byte 4n+j (R2)
  always @(posedge clk) begin
    if (memRead) begin
      for (int j = 0; j < 4; j++) memRdata[8*j +: 8] <= memByte(4 * int'(memOffset) + j, seed);
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expectWord(int addr);
    logic [31:0] w;
    for (int i = 0; i < 4; i++) w[8*i +: 8] = memByte((addr + i) % BYTES, seed);
    return w;
  endfunction

  // one load; optionally keep a different request pending while busy
  task automatic doLoad(input int addr, input bit pestBusy);
    int lane;
    int row;
    int cyc;
    lane = addr % 4;
    row  = addr / 4;
    @(negedge clk);
    reqValid = 1'b1;
    reqAddr  = ADDR_W'(addr);
    #1;
    check(reqReady == 1'b1, "R7 ready before accept", 32'(reqReady), 32'd1);
    check(memRead == 1'b1 && int'(memOffset) == row, "R4 first beat offset",
          32'(memOffset), 32'(row));
    @(posedge clk);
    @(negedge clk);
    if (pestBusy) reqAddr = ADDR_W'((addr + 7) % BYTES);
    else reqValid = 1'b0;
    check(reqReady == 1'b0, "R7 busy after accept", 32'(reqReady), 32'd0);
    if (lane == 0)
      check(memRead == 1'b0, "R3 single beat", 32'(memRead), 32'd0);
    else
      check(memRead == 1'b1 && int'(memOffset) == (row + 1) % (1 << OFFSET_W),
            "R6 second beat offset", 32'(memOffset), 32'((row + 1) % (1 << OFFSET_W)));
    cyc = 1;
    while (!rspValid && cyc < 6) begin
      @(posedge clk);
      @(negedge clk);
      cyc++;
      if (!rspValid)
        check(reqReady == 1'b0, "R7 busy until response", 32'(reqReady), 32'd0);
    end
    reqValid = 1'b0;
    if (lane == 0)
      check(cyc == 2, "R3 aligned latency", 32'(cyc), 32'd2);
    else
      check(cyc == 3, "R10 misaligned latency", 32'(cyc), 32'd3);
    check(rspData == expectWord(addr), "R5 merged word", rspData, expectWord(addr));
    check(reqReady == 1'b1, "R7 ready on response", 32'(reqReady), 32'd1);
    @(posedge clk);
    @(negedge clk);
    check(rspValid == 1'b0, "R8 single pulse", 32'(rspValid), 32'd0);
    check(memRead == 1'b0, "R9 idle no read", 32'(memRead), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(reqReady == 1'b1 && rspValid == 1'b0 && memRead == 1'b0, "R1 in reset",
          {29'd0, reqReady, rspValid, memRead}, 32'h4);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1 && rspValid == 1'b0 && memRead == 1'b0, "R1 after reset",
          {29'd0, reqReady, rspValid, memRead}, 32'h4);
    repeat (4) begin
      @(negedge clk);
      check(memRead == 1'b0, "R9 idle", 32'(memRead), 32'd0);
    end
    // R2 R5: ascending sweep of every byte address, first pattern
    seed = 0;
    for (int a = 0; a < BYTES; a++) doLoad(a, 1'b0);
    // R6: descending sweep with a second pattern, last row first
    seed = 5;
    for (int a = BYTES - 1; a >= 0; a--) doLoad(a, 1'b0);
    // R7: requests held during busy cycles are ignored
    seed = 9;
    for (int a = 0; a < BYTES; a += 3) doLoad(a, 1'b1);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule